// File: doc/BRIEF.md
# Digital PWM Switch Controller for a DC-DC Converter

This block produces the switch-drive timing for a pulse-width-modulated DC-DC converter. A fixed-length switching period is counted on the system clock. At the start of every period the switch is turned on, and it stays on for an internally regulated number of cycles. That on time moves by one cycle at each period boundary. The direction comes from a synchronous comparator input that says whether the regulated output is below or above its target. Two drive outputs are produced, and the second is always the inverse of the first.

Software controls the block through a small byte-wide register port. This port sets the period length, a trim that sets the minimum off time in each period, and an off bit that stops the converter. A calibration request bit holds the switch off for a fixed time. The current on time can be read back but not written. An overload input blanks the switch for the rest of the current period, whatever the register settings.

Top module: `pwm_dcdc_ctrl`

## Requirements
- R1: After reset, the period field reads 63, the trim field reads 0, the converter-off bit reads 1, and the on-time value reads 0. The primary drive is low.
- R2: The output drvNeg is the logical inverse of drvPos in every cycle.
- R3: Register address 0 holds the period field P. While running, a period lasts P+1 clock cycles. A value written during a period takes effect only at the next period boundary.
- R4: In each period, drvPos is high from the first cycle of the period for exactly W cycles. W is the on-time value, and it is readable at address 3.
- R5: At each period boundary, W rises by 1 when vBelow is 1 (output below target). It falls by 1 when vBelow is 0.
- R6: The low field of address 1 (bits 4:0) is a trim T. W never exceeds (P+1)-(T+4), and it never goes below 0. This guarantees at least T+4 off cycles in every period.
- R7: When overload is 1 in a cycle, drvPos is low from the next cycle to the end of the period. It is released at the next period start. An overload in the last cycle of a period blanks the whole next period.
- R8: While bit 4 of address 2 is 1, the converter is off: drvPos stays low and W is held at 0.
- R9: Writing 1 to bit 7 of address 1 starts a calibration. Bit 7 reads 1 for exactly 64 cycles and then clears itself. drvPos is low during this time, and W is kept.
- R10: Writes to address 3 are ignored, so W is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| vBelow | input | 1 | 1 when the sensed output is below target |
| overload | input | 1 | Synchronous overload flag |
| drvPos | output | 1 | Switch drive, active high |
| drvNeg | output | 1 | Switch drive, inverse polarity |

## Verification
Overload blanking and the period boundary can fall in the same cycle. One rule resolves that clash: the overload set wins over the release at the boundary. The bench aligns to a rising drive edge and counts to the last cycle of the period. It raises overload for that single cycle. It then expects every cycle of the following period to be dark and the drive to return exactly one period later. A second case pulses overload on the first cycle of a period, and the bench checks that the pulse ends at once and recovers on time.

// File: rtl/pwm_dcdc_pkg.sv
package pwm_dcdc_pkg;

  // register addresses
  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_DELAY  = 2'd1;
  localparam logic [1:0] ADDR_POWER  = 2'd2;
  localparam logic [1:0] ADDR_WIDTH  = 2'd3;

  // bit positions inside registers
  localparam int CAL_BIT = 7;
  localparam int OFF_BIT = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic run;        // converter switching this cycle
    logic periodEnd;  // last cycle of the current period
    logic clrWidth;   // force on time to zero
  } ctlStrb_t;

endpackage

// File: rtl/pwm_dcdc_control.sv
module pwm_dcdc_control
  import pwm_dcdc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int TRIM_W     = 5,
  parameter int CAL_CYCLES = 64,
  parameter int PERIOD_RST = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  activePeriod,
  output logic [CNT_W-1:0]  periodReg,
  output logic [TRIM_W-1:0] offTrim,
  output logic              convOff,
  output logic              calBusy,
  output ctlStrb_t          strb
);

  localparam int CAL_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_CYCLES - 1);

  logic [CAL_W-1:0] calCnt;
  logic run;
  logic periodEnd;
  logic wrDelay;

  assign run       = !convOff && !calBusy;
  assign periodEnd = run && (cnt == activePeriod);
  assign wrDelay   = wrEn && (wrAddr == ADDR_DELAY);

  assign strb.run       = run;
  assign strb.periodEnd = periodEnd;
  assign strb.clrWidth  = convOff;

  // software-visible fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= CNT_W'(PERIOD_RST);
      offTrim   <= '0;
      convOff   <= 1'b1;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PERIOD: periodReg <= wrData[CNT_W-1:0];
        ADDR_DELAY:  offTrim   <= wrData[TRIM_W-1:0];
        ADDR_POWER:  convOff   <= wrData[OFF_BIT];
        default: ;
      endcase
    end
  end

  // calibration timer, self clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calBusy <= 1'b0;
      calCnt  <= '0;
    end else if (calBusy) begin
      if (calCnt == CAL_LAST) begin
        calBusy <= 1'b0;
        calCnt  <= '0;
      end else begin
        calCnt <= calCnt + 1'b1;
      end
    end else if (wrDelay && wrData[CAL_BIT]) begin
      calBusy <= 1'b1;
      calCnt  <= '0;
    end
  end

  // period counter and boundary latch of the period length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt          <= '0;
      activePeriod <= CNT_W'(PERIOD_RST);
    end else if (!run || periodEnd) begin
      cnt          <= '0;
      activePeriod <= periodReg;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !periodEnd) |=> $stable(activePeriod));

  // R8
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    convOff |=> (cnt == '0));

endmodule

// File: rtl/pwm_dcdc_datapath.sv
module pwm_dcdc_datapath
  import pwm_dcdc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TRIM_W    = 5,
  parameter int FIXED_OFF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  activePeriod,
  input  logic [CNT_W-1:0]  periodReg,
  input  logic [TRIM_W-1:0] offTrim,
  input  logic              vBelow,
  input  logic              overload,
  output logic [CNT_W-1:0]  width,
  output logic              drvOn
);

  localparam int EXT_W = (CNT_W > TRIM_W ? CNT_W : TRIM_W) + 2;

  logic [EXT_W-1:0] minOff;
  logic [EXT_W-1:0] lenCur, lenNext;
  logic [EXT_W-1:0] maxCur, maxNext;
  logic [EXT_W-1:0] widthExt, widthNext;
  logic             blank;

  assign minOff   = EXT_W'(offTrim) + EXT_W'(FIXED_OFF);
  assign lenCur   = EXT_W'(activePeriod) + 1'b1;
  assign lenNext  = EXT_W'(periodReg) + 1'b1;
  assign maxCur   = (lenCur  > minOff) ? lenCur  - minOff : '0;
  assign maxNext  = (lenNext > minOff) ? lenNext - minOff : '0;
  assign widthExt = EXT_W'(width);

  // one-step regulation with clamping against the coming period
  always_comb begin
    widthNext = widthExt;
    if (vBelow && (widthExt < maxNext)) begin
      widthNext = widthExt + 1'b1;
    end else if (!vBelow && (width != '0)) begin
      widthNext = widthExt - 1'b1;
    end
    if (widthNext > maxNext) begin
      widthNext = maxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      width <= '0;
    end else if (strb.clrWidth) begin
      width <= '0;
    end else if (strb.periodEnd) begin
      width <= widthNext[CNT_W-1:0];
    end
  end

  // overload blanking: set wins over release at the boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blank <= 1'b0;
    end else if (overload) begin
      blank <= 1'b1;
    end else if (strb.periodEnd || !strb.run) begin
      blank <= 1'b0;
    end
  end

  assign drvOn = strb.run && !blank
               && (EXT_W'(cnt) < widthExt)
               && (EXT_W'(cnt) < maxCur);

  // R7
  overload_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    overload |=> !drvOn);

  // R5
  width_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.periodEnd && !strb.clrWidth) |=> $stable(width));

endmodule

// File: rtl/pwm_dcdc_ctrl.sv
module pwm_dcdc_ctrl
  import pwm_dcdc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int TRIM_W     = 5,
  parameter int FIXED_OFF  = 4,
  parameter int CAL_CYCLES = 64,
  parameter int PERIOD_RST = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              vBelow,
  input  logic              overload,
  output logic              drvPos,
  output logic              drvNeg
);

  ctlStrb_t          strb;
  logic [CNT_W-1:0]  cnt, activePeriod, periodReg, width;
  logic [TRIM_W-1:0] offTrim;
  logic              convOff, calBusy, drvOn;

  pwm_dcdc_control #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .TRIM_W(TRIM_W),
    .CAL_CYCLES(CAL_CYCLES), .PERIOD_RST(PERIOD_RST)
  ) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cnt(cnt), .activePeriod(activePeriod), .periodReg(periodReg),
    .offTrim(offTrim), .convOff(convOff), .calBusy(calBusy), .strb(strb)
  );

  pwm_dcdc_datapath #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .FIXED_OFF(FIXED_OFF)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt),
    .activePeriod(activePeriod), .periodReg(periodReg), .offTrim(offTrim),
    .vBelow(vBelow), .overload(overload), .width(width), .drvOn(drvOn)
  );

  assign drvPos = drvOn;
  assign drvNeg = !drvOn;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_PERIOD: rdData = DATA_W'(periodReg);
      ADDR_DELAY: begin
        rdData = DATA_W'(offTrim);
        rdData[CAL_BIT] = calBusy;
      end
      ADDR_POWER: rdData[OFF_BIT] = convOff;
      default:    rdData = DATA_W'(width);
    endcase
  end

  // R9
  cal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |-> !drvPos);

endmodule

// File: tb/tb_pwm_dcdc_ctrl.sv
`timescale 1ns/100ps
module tb_pwm_dcdc_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       vBelow = 1'b0;
  logic       overload = 1'b0;
  logic       drvPos, drvNeg;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dcdc_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .vBelow(vBelow), .overload(overload),
    .drvPos(drvPos), .drvNeg(drvNeg)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rdAddr = a;
    #0.1;
    v = int'(rdData);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count high samples of drvPos over n cycles, tracking polarity errors
  task automatic countOn(input int n, output int on, inout int polErr);
    on = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (drvPos) on++;
      if (drvNeg == drvPos) polErr++;
    end
  endtask

  // samples until the next rising edge of drvPos
  task automatic nextRise(output int n);
    logic prev;
    prev = drvPos;
    n = 0;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      if (!prev && drvPos) break;
      prev = drvPos;
    end
  endtask

  task automatic tReset();
    int v;
    rd(2'd0, v); chk("R1 period", v, 63);
    rd(2'd1, v); chk("R1 trim", v, 0);
    rd(2'd2, v); chk("R1 off bit", v, 8'h10);
    rd(2'd3, v); chk("R1 width", v, 0);
    chk("R1 drive", int'(drvPos), 0);
    chk("R2 inverse at reset", int'(drvNeg), 1);
  endtask

  task automatic tSteady();
    int v, on, pol;
    pol = 0;
    vBelow = 1'b1;
    wr(2'd0, 8'd9);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h00);
    idle(100);
    rd(2'd3, v); chk("R6 clamp trim 2", v, 4);
    countOn(100, on, pol);
    chk("R4 on cycles trim 2", on, 40);
    chk("R2 inverse", pol, 0);
  endtask

  task automatic tMinOff();
    int v, on, pol;
    pol = 0;
    wr(2'd1, 8'h00);
    idle(60);
    rd(2'd3, v); chk("R6 clamp trim 0", v, 6);
    countOn(100, on, pol);
    chk("R4 on cycles trim 0", on, 60);
    chk("R2 inverse trim 0", pol, 0);
  endtask

  task automatic tOverload();
    int n, acc;
    nextRise(n);
    overload = 1'b1;
    @(negedge clk);
    overload = 1'b0;
    acc = 0;
    for (int i = 0; i < 9; i++) begin
      acc += int'(drvPos);
      @(negedge clk);
    end
    chk("R7 blank rest of period", acc, 0);
    chk("R7 release next period", int'(drvPos), 1);
  endtask

  task automatic tOverloadAtEnd();
    int n, acc;
    nextRise(n);
    idle(9);
    overload = 1'b1;
    @(negedge clk);
    overload = 1'b0;
    acc = 0;
    for (int i = 0; i < 10; i++) begin
      acc += int'(drvPos);
      @(negedge clk);
    end
    chk("R7 boundary overload blanks next period", acc, 0);
    chk("R7 boundary overload release", int'(drvPos), 1);
  endtask

  task automatic tPeriodChange();
    int n, v0, v1;
    logic prev;
    nextRise(n);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'd19;
    prev = 1'b1;
    n = 0;
    while (n < 2000) begin
      @(negedge clk);
      wrEn = 1'b0;
      n++;
      if (!prev && drvPos) break;
      prev = drvPos;
    end
    chk("R3 mid-period write deferred", n, 10);
    nextRise(n);
    chk("R3 new period length", n, 20);
    rd(2'd3, v0);
    idle(20);
    rd(2'd3, v1);
    chk("R5 step up", v1 - v0, 1);
    vBelow = 1'b0;
    idle(20);
    rd(2'd3, v0);
    chk("R5 step down", v1 - v0, 1);
  endtask

  task automatic tFloor();
    int v, on, pol;
    pol = 0;
    idle(400);
    rd(2'd3, v); chk("R6 floor at zero", v, 0);
    countOn(40, on, pol);
    chk("R6 no drive at zero width", on, 0);
  endtask

  task automatic tConvOff();
    int v, on, pol;
    pol = 0;
    vBelow = 1'b1;
    wr(2'd2, 8'h10);
    countOn(60, on, pol);
    chk("R8 no drive while off", on, 0);
    rd(2'd3, v); chk("R8 width held zero", v, 0);
  endtask

  task automatic tCalibrate();
    int v, busy, on, pol;
    wr(2'd0, 8'd9);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h00);
    idle(150);
    rd(2'd3, v); chk("R6 regained clamp", v, 4);
    wr(2'd1, 8'h82);
    busy = 0; on = 0; pol = 0;
    for (int i = 0; i < 90; i++) begin
      rd(2'd1, v);
      if (v[7]) begin
        busy++;
        if (drvPos) on++;
      end
      @(negedge clk);
    end
    chk("R9 busy length", busy, 64);
    chk("R9 no drive during cal", on, 0);
    rd(2'd1, v); chk("R9 trim kept", v, 2);
    rd(2'd3, v); chk("R9 width kept", v, 4);
  endtask

  task automatic tReadOnly();
    int v;
    wr(2'd3, 8'hAA);
    rd(2'd3, v); chk("R10 width write ignored", v, 4);
    idle(3);
    rd(2'd3, v); chk("R10 width still", v, 4);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSteady();
    tMinOff();
    tOverload();
    tOverloadAtEnd();
    tPeriodChange();
    tFloor();
    tConvOff();
    tCalibrate();
    tReadOnly();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule